// File: doc/BRIEF.md
# FIFO Programmable Fill-Level Flag

This block produces a programmable fill-level status flag for a group of byte FIFOs. Each FIFO can face either direction: host-to-device (OUT) or device-to-host (IN). For each FIFO the block keeps three counts:

- the total number of bytes held;
- the bytes written so far into the packet being assembled;
- the number of packets already committed.

Each FIFO's counts are compared against that FIFO's configured threshold. A direction bit chooses between an at-or-below test and an at-or-above test, and the result is stored in a register. A 2-bit address picks which FIFO's flag appears on the single shared flag pin.

The threshold can be read in three ways:

- in OUT mode, as a byte count for the whole FIFO;
- in IN mode with the packet-only option set, as a byte count inside the current packet;
- in IN mode with that option clear, as a pair (committed packets, current-packet bytes), compared with packets as the more significant part.

A packet is committed in one of two ways. The first is automatic, when a write fills it to the maximum packet size. The second is a packet-end strobe. A committed packet is retired once the reader has drained its last byte. The surrounding logic supplies the write, read and packet-end strobes, and loads each FIFO's configuration through a one-word write port.

Top module: `pf_level_flag`

## Requirements
- R1: Synchronous active-low reset clears every count. Reset loads the default configuration. FIFOs in the lower half of the index range get OUT mode with the at-or-above test and threshold DEF_THR. FIFOs in the upper half get IN mode with the packet pair test (packet-only option clear), the at-or-below test and threshold {DEF_THR / MAX_PKT packets, DEF_THR % MAX_PKT bytes}. Each flag holds the result of its default configuration against zero counts while reset is applied and afterwards.
- R2: The total byte count rises by one on a cycle with only a write strobe. It falls by one on a cycle with only a read strobe. It holds when both strobes occur in the same cycle.
- R3: In OUT mode (cfg_is_in = 0) the level is the total byte count, compared against the 13-bit cfg_thr.
- R4: cfg_ge = 0 makes the flag true when level <= threshold. cfg_ge = 1 makes it true when level >= threshold. This holds in every mode.
- R5: In IN mode with cfg_pkt_only = 1, the level is the current-packet byte count, compared against cfg_thr[9:0].
- R6: In IN mode with cfg_pkt_only = 0, the pair {committed packets, current-packet bytes} is compared lexicographically against {cfg_thr_pk, cfg_thr[9:0]}.
- R7: A write that brings the current packet to MAX_PKT bytes commits that packet. The current count returns to 0 and the committed-packet count rises by one.
- R8: A packet-end strobe commits the current packet, including a byte written in the same cycle. A packet-end strobe with an empty current packet and no write has no effect.
- R9: A read while at least one packet is committed consumes a byte of the oldest committed packet. Reading that packet's last byte lowers the committed-packet count by one. A read with no committed packet changes only the total.
- R10: A strobe sampled at clock edge k changes the counts at edge k. The flag reflects them at edge k+1.
- R11: flag_out shows, without a clock delay, the registered flag of the FIFO whose index is on fifo_adr.
- R12: cfg_we with cfg_sel = i replaces FIFO i's configuration at that edge. FIFO i's flag reflects the new configuration one edge later. Other FIFOs' configurations and all counts are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | NUM_FIFO | Per-FIFO byte write strobe |
| rd_stb | input | NUM_FIFO | Per-FIFO byte read strobe |
| pkt_end | input | NUM_FIFO | Per-FIFO packet-end (commit) strobe |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_sel | input | AW | FIFO index whose configuration is loaded |
| cfg_is_in | input | 1 | 1 = IN direction, 0 = OUT |
| cfg_pkt_only | input | 1 | IN mode: compare current-packet bytes only |
| cfg_ge | input | 1 | 1 = at-or-above test, 0 = at-or-below test |
| cfg_thr | input | 13 | Byte threshold (low 10 bits in IN modes) |
| cfg_thr_pk | input | 3 | Packet part of the pair threshold |
| fifo_adr | input | AW | Selects the FIFO shown on flag_out |
| flag_out | output | 1 | Selected programmable-level flag |

## Verification
The hardest state to reach is a pair comparison near its boundaries. That needs several committed packets plus a partly filled current packet at exactly the chosen position. Reaching it also requires draining packets in order, so that retirement happens on the right byte. The bench uses a small maximum packet size, so automatic commits come within a few writes. It interleaves packet-end strobes with pseudo-random writes and reads that respect the packet count. It then sweeps the pair threshold across every packet and byte value around the reached level, in both test directions. The bench also checks the one-cycle flag delay directly, by sampling between the two edges.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int TOT_W = 13;  // total byte count / OUT threshold width
  localparam int PB_W  = 10;  // current-packet byte count width
  localparam int PC_W  = 3;   // committed-packet count width

  typedef struct packed {
    logic              is_in;
    logic              pkt_only;
    logic              ge;
    logic [TOT_W-1:0]  thr;
    logic [PC_W-1:0]   thr_pk;
  } pf_cfg_t;

  function automatic logic pf_cmp(input logic ge, input logic [PC_W+TOT_W-1:0] lvl,
                                  input logic [PC_W+TOT_W-1:0] lim);
    return ge ? (lvl >= lim) : (lvl <= lim);
  endfunction

  function automatic logic pf_eval(input pf_cfg_t c, input logic [TOT_W-1:0] tot,
                                   input logic [PB_W-1:0] cur, input logic [PC_W-1:0] pk);
    logic [PC_W+TOT_W-1:0] lvl;
    logic [PC_W+TOT_W-1:0] lim;
    if (!c.is_in) begin
      lvl = {{PC_W{1'b0}}, tot};
      lim = {{PC_W{1'b0}}, c.thr};
    end else if (c.pkt_only) begin
      lvl = {{(PC_W+TOT_W-PB_W){1'b0}}, cur};
      lim = {{(PC_W+TOT_W-PB_W){1'b0}}, c.thr[PB_W-1:0]};
    end else begin
      lvl = {{(TOT_W-PB_W){1'b0}}, pk, cur};
      lim = {{(TOT_W-PB_W){1'b0}}, c.thr_pk, c.thr[PB_W-1:0]};
    end
    return pf_cmp(c.ge, lvl, lim);
  endfunction
endpackage

// File: rtl/pf_cfg_slot.sv
module pf_cfg_slot
  import pf_pkg::*;
#(
  parameter bit IS_IN_DEF = 1'b0,
  parameter int DEF_THR   = 512,
  parameter int MAX_PKT   = 512
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    we,
  input  pf_cfg_t cfg_d,
  output pf_cfg_t cfg_q
);
  localparam int DEF_PK = DEF_THR / MAX_PKT;
  localparam int DEF_BY = DEF_THR % MAX_PKT;

  pf_cfg_t cfg_def;
  always_comb begin
    cfg_def.is_in    = IS_IN_DEF;
    cfg_def.pkt_only = 1'b0;
    cfg_def.ge       = !IS_IN_DEF;
    cfg_def.thr      = IS_IN_DEF ? TOT_W'(DEF_BY) : TOT_W'(DEF_THR);
    cfg_def.thr_pk   = IS_IN_DEF ? PC_W'(DEF_PK) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  cfg_q <= cfg_def;
    else if (we) cfg_q <= cfg_d;
  end

  // R12
  cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg_q));
endmodule

// File: rtl/pf_level_track.sv
module pf_level_track
  import pf_pkg::*;
#(
  parameter int MAX_PKT = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic             pe,
  output logic [TOT_W-1:0] tot,
  output logic [PB_W-1:0]  cur,
  output logic [PC_W-1:0]  pk
);
  localparam int QD = 2 ** PC_W;

  logic [PB_W-1:0] len_q [QD];
  logic [PC_W-1:0] hd, tl;
  logic [PB_W-1:0] off;

  logic            auto_evt, pe_evt, commit_evt, head_rd, pop_evt;
  logic [PB_W-1:0] cur_inc, off_inc;

  assign cur_inc    = cur + PB_W'(wr);
  assign off_inc    = off + PB_W'(1);
  assign auto_evt   = wr && (cur == PB_W'(MAX_PKT - 1));
  assign pe_evt     = pe && (wr || (cur != '0));
  assign commit_evt = auto_evt || pe_evt;
  assign head_rd    = rd && (pk != '0);
  assign pop_evt    = head_rd && (off_inc == len_q[hd]);

  always_ff @(posedge clk) begin
    if (commit_evt) len_q[tl] <= cur_inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tot <= '0;
      cur <= '0;
      pk  <= '0;
      hd  <= '0;
      tl  <= '0;
      off <= '0;
    end else begin
      tot <= tot + TOT_W'(wr) - TOT_W'(rd);
      cur <= commit_evt ? '0 : cur_inc;
      pk  <= pk + PC_W'(commit_evt) - PC_W'(pop_evt);
      if (commit_evt) tl <= tl + PC_W'(1);
      if (pop_evt)    hd <= hd + PC_W'(1);
      if (head_rd)    off <= pop_evt ? '0 : off_inc;
    end
  end

  // R2
  tot_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !rd) |=> (tot == $past(tot) + TOT_W'(1)));
  // R2
  tot_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr) |=> (tot == $past(tot) - TOT_W'(1)));
  // R2
  tot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && wr) |=> $stable(tot));
  // R7
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_evt |=> (cur == '0));
  // R7
  cur_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur < PB_W'(MAX_PKT));
  // R8
  pe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pe && !wr && !rd && cur == '0) |=> ($stable(cur) && $stable(pk)));
  // R9
  pkt_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && !commit_evt) |=> (pk == $past(pk) - PC_W'(1)));
endmodule

// File: rtl/pf_flag_cmp.sv
module pf_flag_cmp
  import pf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  pf_cfg_t          cfg,
  input  logic [TOT_W-1:0] tot,
  input  logic [PB_W-1:0]  cur,
  input  logic [PC_W-1:0]  pk,
  output logic             flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag <= pf_eval(cfg, '0, '0, '0);
    else        flag <= pf_eval(cfg, tot, cur, pk);
  end

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(tot) && $stable(cur) && $stable(pk) && $stable(cfg)) |=> $stable(flag));
endmodule

// File: rtl/pf_level_flag.sv
module pf_level_flag
  import pf_pkg::*;
#(
  parameter int NUM_FIFO = 4,
  parameter int MAX_PKT  = 512,
  parameter int DEF_THR  = 512,
  localparam int AW      = $clog2(NUM_FIFO)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_FIFO-1:0] wr_stb,
  input  logic [NUM_FIFO-1:0] rd_stb,
  input  logic [NUM_FIFO-1:0] pkt_end,
  input  logic                cfg_we,
  input  logic [AW-1:0]       cfg_sel,
  input  logic                cfg_is_in,
  input  logic                cfg_pkt_only,
  input  logic                cfg_ge,
  input  logic [TOT_W-1:0]    cfg_thr,
  input  logic [PC_W-1:0]     cfg_thr_pk,
  input  logic [AW-1:0]       fifo_adr,
  output logic                flag_out
);
  pf_cfg_t             cfg_word;
  logic [NUM_FIFO-1:0] flags;

  always_comb begin
    cfg_word.is_in    = cfg_is_in;
    cfg_word.pkt_only = cfg_pkt_only;
    cfg_word.ge       = cfg_ge;
    cfg_word.thr      = cfg_thr;
    cfg_word.thr_pk   = cfg_thr_pk;
  end

  for (genvar i = 0; i < NUM_FIFO; i++) begin : g_fifo
    pf_cfg_t          cfg_i;
    logic [TOT_W-1:0] tot_i;
    logic [PB_W-1:0]  cur_i;
    logic [PC_W-1:0]  pk_i;
    logic             we_i;

    assign we_i = cfg_we && (cfg_sel == AW'(i));

    pf_cfg_slot #(
      .IS_IN_DEF (i >= NUM_FIFO / 2),
      .DEF_THR   (DEF_THR),
      .MAX_PKT   (MAX_PKT)
    ) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we_i),
      .cfg_d (cfg_word),
      .cfg_q (cfg_i)
    );

    pf_level_track #(.MAX_PKT(MAX_PKT)) u_trk (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_stb[i]),
      .rd    (rd_stb[i]),
      .pe    (pkt_end[i]),
      .tot   (tot_i),
      .cur   (cur_i),
      .pk    (pk_i)
    );

    pf_flag_cmp u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .cfg   (cfg_i),
      .tot   (tot_i),
      .cur   (cur_i),
      .pk    (pk_i),
      .flag  (flags[i])
    );
  end

  assign flag_out = flags[fifo_adr];

  // R11
  flag_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(flags) && $stable(fifo_adr)) |-> $stable(flag_out));
endmodule

// File: tb/pf_level_flag_test.sv
module pf_level_flag_test;
  localparam int CLK_PERIOD = 10;
  localparam int NF   = 4;
  localparam int MAXP = 8;
  localparam int DTHR = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NF-1:0] wr_stb = '0, rd_stb = '0, pkt_end = '0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic          cfg_is_in = 1'b0, cfg_pkt_only = 1'b0, cfg_ge = 1'b0;
  logic [12:0]   cfg_thr = '0;
  logic [2:0]    cfg_thr_pk = '0;
  logic [1:0]    fifo_adr = '0;
  logic          flag_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_tot[NF], m_cur[NF], m_pk[NF], m_off[NF], m_hd[NF], m_tl[NF];
  int m_q[NF][8];
  bit m_in[NF], m_po[NF], m_ge[NF];
  int m_thr[NF], m_tp[NF];
  logic [15:0] lf = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  pf_level_flag #(.NUM_FIFO(NF), .MAX_PKT(MAXP), .DEF_THR(DTHR)) uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .pkt_end(pkt_end),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_is_in(cfg_is_in), .cfg_pkt_only(cfg_pkt_only),
    .cfg_ge(cfg_ge), .cfg_thr(cfg_thr), .cfg_thr_pk(cfg_thr_pk), .fifo_adr(fifo_adr),
    .flag_out(flag_out));

  function automatic bit exp_flag(int i);
    int lvl, lim;
    if (!m_in[i]) begin lvl = m_tot[i]; lim = m_thr[i]; end
    else if (m_po[i]) begin lvl = m_cur[i]; lim = m_thr[i] % 1024; end
    else begin lvl = m_pk[i] * 1024 + m_cur[i]; lim = m_tp[i] * 1024 + m_thr[i] % 1024; end
    return m_ge[i] ? (lvl >= lim) : (lvl <= lim);
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag, input int a);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s fifo %0d: flag_out=%b expected %b", tag, a, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < NF; a++) begin
      fifo_adr = a[1:0];
      #1;
      chk(flag_out, exp_flag(a), tag, a);
    end
  endtask

  task automatic model_step(input int i, input bit w, input bit r, input bit p);
    bit au, pc, cm, pop;
    int len;
    au  = w && (m_cur[i] == MAXP - 1);
    pc  = p && (w || m_cur[i] != 0);
    cm  = au || pc;
    len = m_cur[i] + w;
    pop = 0;
    if (r && m_pk[i] > 0) begin
      if (m_off[i] + 1 == m_q[i][m_hd[i]]) begin pop = 1; m_off[i] = 0; m_hd[i] = (m_hd[i] + 1) % 8; end
      else m_off[i]++;
    end
    m_tot[i] = m_tot[i] + w - r;
    m_cur[i] = cm ? 0 : len;
    if (cm) begin m_q[i][m_tl[i]] = len; m_tl[i] = (m_tl[i] + 1) % 8; end
    m_pk[i] = m_pk[i] + cm - pop;
  endtask

  // called at a falling edge; returns at a falling edge two rising edges later
  task automatic step(input logic [NF-1:0] w, input logic [NF-1:0] r,
                      input logic [NF-1:0] p, input string tag);
    wr_stb = w; rd_stb = r; pkt_end = p;
    for (int i = 0; i < NF; i++) model_step(i, w[i], r[i], p[i]);
    @(negedge clk);
    wr_stb = '0; rd_stb = '0; pkt_end = '0;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic cfg_load(input int i, input bit in_, input bit po, input bit ge,
                          input int thr, input int tp, input string tag);
    cfg_we = 1'b1; cfg_sel = i[1:0]; cfg_is_in = in_; cfg_pkt_only = po; cfg_ge = ge;
    cfg_thr = thr[12:0]; cfg_thr_pk = tp[2:0];
    m_in[i] = in_; m_po[i] = po; m_ge[i] = ge; m_thr[i] = thr; m_tp[i] = tp;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    check_all(tag);
  endtask

  function automatic bit can_wr(int i);
    return (m_tot[i] < 1000) && (m_pk[i] < 6);
  endfunction
  function automatic bit can_rd(int i);
    return m_in[i] ? (m_pk[i] > 0) : (m_tot[i] > 0);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R10: run not finished, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NF-1:0] w, r, p;
    bit old_f;
    for (int i = 0; i < NF; i++) begin
      m_tot[i] = 0; m_cur[i] = 0; m_pk[i] = 0; m_off[i] = 0; m_hd[i] = 0; m_tl[i] = 0;
      m_in[i] = (i >= NF / 2); m_po[i] = 0; m_ge[i] = !m_in[i];
      m_thr[i] = m_in[i] ? DTHR % MAXP : DTHR; m_tp[i] = m_in[i] ? DTHR / MAXP : 0;
    end
    repeat (3) @(negedge clk);
    check_all("R1 during reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1 after reset");

    // R12: per-FIFO configuration load
    cfg_load(0, 0, 0, 1, 1, 0, "R12 R3");
    cfg_load(1, 0, 0, 0, 12, 0, "R12 R4");
    cfg_load(2, 1, 1, 1, 5, 0, "R12 R5");
    cfg_load(3, 1, 0, 1, 3, 2, "R12 R6");

    // R10: flag appears on the second edge after the strobe
    old_f = exp_flag(0);
    fifo_adr = 2'd0;
    wr_stb = 4'b0001; model_step(0, 1, 0, 0);
    @(negedge clk);
    wr_stb = '0;
    #1 chk(flag_out, old_f, "R10 before second edge", 0);
    @(negedge clk);
    #1 chk(flag_out, exp_flag(0), "R10 after second edge", 0);
    cfg_load(0, 0, 0, 1, 12, 0, "R12 R3");

    // ramp writes: R2 R3 R5 R6 R7
    for (int k = 0; k < 30; k++) step(4'b1111, '0, '0, "R2 R3 R5 R6 R7 ramp");
    // drain: R2 R9
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < NF; i++) r[i] = can_rd(i);
      step('0, r, '0, "R2 R9 drain");
    end
    // packet-end commits: R8
    for (int k = 0; k < 3; k++) step(4'b1100, '0, '0, "R8 fill");
    step('0, '0, 4'b1100, "R8 commit");
    step('0, '0, 4'b1100, "R8 empty end ignored");
    step(4'b1100, '0, 4'b1100, "R8 write with end");
    // simultaneous read and write: R2
    for (int k = 0; k < 6; k++) step(4'b0011, '0, '0, "R2 prefill");
    for (int k = 0; k < 5; k++) step(4'b0011, 4'b0011, '0, "R2 rd+wr hold");

    // pseudo-random mix: R2 R7 R8 R9
    for (int k = 0; k < 400; k++) begin
      for (int i = 0; i < NF; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        w[i] = lf[0] && can_wr(i);
        r[i] = lf[1] && can_rd(i);
        p[i] = lf[2] && lf[3] && (m_pk[i] < 6);
      end
      step(w, r, p, "R2 R7 R8 R9 mix");
    end

    // threshold sweeps at the reached levels: R3 R4 R5 R6
    for (int t = 0; t < 48; t++)
      for (int g = 0; g < 2; g++) cfg_load(0, 0, 0, g[0], t, 0, "R3 R4 sweep");
    for (int t = 0; t < MAXP + 1; t++)
      for (int g = 0; g < 2; g++) cfg_load(2, 1, 1, g[0], t, 0, "R5 R4 sweep");
    for (int tp = 0; tp < 8; tp++)
      for (int t = 0; t < MAXP + 1; t++)
        for (int g = 0; g < 2; g++) cfg_load(3, 1, 0, g[0], t, tp, "R6 R4 sweep");
    // OUT mode on an upper FIFO and pair mode on a lower one: R12 R11
    cfg_load(2, 0, 0, 1, m_tot[2], 0, "R12 R11 R3");
    cfg_load(1, 1, 0, 0, m_cur[1], m_pk[1], "R12 R11 R6");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule